// File: doc/BRIEF.md
# Parity-Protected Bus Fabric Monitor

This block sits on an internal address/data bus that joins four agents: a buffer manager, a host serial port, a register bridge and an SRAM controller. Requests travel from a requester to a target. Read responses travel back from the target to the requester. On each of the two paths the block adds one even-parity bit over the address and a second one over the data when the transfer enters, and carries both bits through a one-cycle hop. The receiving agent checks both bits on the far side of the hop.

When checking is on and a received transfer fails its check, the block drops the transfer. It then sets a sticky flag for the agent that detected the fault, sets a global bus-error bit and, if software allows it, raises an interrupt. For fault simulation, software can arm four single-shot injection bits. Each one flips the generated parity of one chosen path and direction. Software reaches the block through a small register port with three registers: control, injection and status.

Register map (5-bit data):
- address 0, control: bit 0 enables checking, bit 1 enables the interrupt.
- address 1, injection: a write of one sets a bit; a read shows the bits still pending. The bits are:
  - bit 0: address parity on any buffer-manager request.
  - bit 1: data parity on buffer-manager write requests.
  - bit 2: data parity on responses sent by the register bridge.
  - bit 3: data parity on responses sent by the SRAM controller.
- address 2, status: writing one clears a bit. Bits 0..3 are the detector flags for the buffer manager (0), the serial port (1), the register bridge (2) and the SRAM controller (3). Bit 4 is the global bus error.
- address 3 reads zero.

Agent codes on the source and destination fields are 0 for the buffer manager, 1 for the serial port, 2 for the register bridge and 3 for the SRAM controller.

Top module: `parbus_guard`

## Requirements
- R1: After reset, the control, injection and status registers read 0, the interrupt is low and no transfer is delivered.
- R2: A request on `req_*` appears on `tgt_*` in the cycle after it is presented, with all fields unchanged. A response on `rsp_*` appears the same way on `ret_*`. When no parity is corrupted, no status bit is set.
- R3: While control bit 0 is 0, the parity bits are still generated, injected and carried. A transfer that fails its check is still delivered, and no status bit changes.
- R4: While control bit 0 is 1, a request or response that fails its address check, or its data check, is not delivered. The data check applies to write requests and to all responses. The valid output stays low in its delivery cycle.
- R5: A failed request sets the status flag of its destination agent. A failed response sets the flag of the requester it was returning to. The flag is visible one cycle after the delivery cycle.
- R6: Any detected failure sets status bit 4 in the same cycle as the agent flag.
- R7: The interrupt output equals status bit 4 AND control bit 1, delayed by one register stage.
- R8: Injection bit 0 corrupts the address parity of buffer-manager reads and writes. Bit 1 corrupts only buffer-manager writes and stays pending across a buffer-manager read. Bits 2 and 3 corrupt only responses from their own source agent.
- R9: An injection bit clears in the cycle in which it corrupts a transfer, so the next transfer on that path is clean.
- R10: Writing a one to a status bit clears it. If the same bit is set by a failure in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data (combinational on reg_addr) |
| req_vld | input | 1 | Request valid |
| req_we | input | 1 | Request is a write |
| req_src | input | 2 | Requesting agent |
| req_dst | input | 2 | Target agent |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| tgt_vld | output | 1 | Request delivered to target |
| tgt_we | output | 1 | Delivered write flag |
| tgt_src | output | 2 | Delivered requester |
| tgt_dst | output | 2 | Delivered target |
| tgt_addr | output | AW | Delivered address |
| tgt_wdata | output | DW | Delivered write data |
| rsp_vld | input | 1 | Read response valid |
| rsp_src | input | 2 | Responding agent |
| rsp_dst | input | 2 | Requester receiving the response |
| rsp_addr | input | AW | Address echoed with the response |
| rsp_rdata | input | DW | Read data |
| ret_vld | output | 1 | Response delivered to requester |
| ret_src | output | 2 | Delivered responder |
| ret_dst | output | 2 | Delivered receiver |
| ret_addr | output | AW | Delivered echoed address |
| ret_rdata | output | DW | Delivered read data |
| irq | output | 1 | Bus-error interrupt |

## Verification
Two things can fall in the same cycle. A failure detection and a software clear can both hit the status register. A new injection arm and the consumption of an older one can both hit the injection register. The bench provokes the first case: one failed request is latched into the hop, and in its delivery cycle a clear-all is written to status. The result is judged by a read in the next cycle: the flag just raised and the global bit must remain, and an older flag from a different agent must be gone. Injection scope is judged on the pending bit as well as on delivery. A bit applied to the wrong path or direction must still read as pending afterwards.

// File: rtl/parbus_pkg.sv
package parbus_pkg;
  localparam int NAG = 4;
  localparam int AGW = $clog2(NAG);
  localparam int RDW = NAG + 1;

  typedef enum logic [AGW-1:0] {
    AG_BM   = 2'd0,
    AG_SPI  = 2'd1,
    AG_BRG  = 2'd2,
    AG_SRAM = 2'd3
  } agent_e;

  localparam int INJ_BM_ADDR = 0;
  localparam int INJ_BM_WDAT = 1;
  localparam int INJ_BRG_RD  = 2;
  localparam int INJ_SRAM_RD = 3;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_INJ  = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  // even parity bit: vector plus this bit holds an even count of ones
  function automatic logic even_bit(input logic [63:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/parbus_hop.sv
module parbus_hop
  import parbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic          in_vld,
  input  logic          in_dchk,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [MW-1:0] in_meta,
  input  logic          inj_a,
  input  logic          inj_d,
  output logic          out_vld,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  output logic [MW-1:0] out_meta,
  output logic          err_pulse
);
  logic          vld_q, dchk_q, pa_q, pd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [MW-1:0] meta_q;
  logic          gen_pa, gen_pd, a_bad, d_bad;

  // sender side: generate, then optionally flip
  assign gen_pa = even_bit(64'(in_addr)) ^ inj_a;
  assign gen_pd = even_bit(64'(in_data)) ^ inj_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      dchk_q <= 1'b0;
      pa_q   <= 1'b0;
      pd_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      meta_q <= '0;
    end else begin
      vld_q  <= in_vld;
      dchk_q <= in_dchk;
      pa_q   <= gen_pa;
      pd_q   <= gen_pd;
      addr_q <= in_addr;
      data_q <= in_data;
      meta_q <= in_meta;
    end
  end

  // receiver side check
  assign a_bad     = even_bit(64'(addr_q)) ^ pa_q;
  assign d_bad     = dchk_q & (even_bit(64'(data_q)) ^ pd_q);
  assign err_pulse = vld_q & chk_en & (a_bad | d_bad);
  assign out_vld   = vld_q & ~err_pulse;
  assign out_addr  = addr_q;
  assign out_data  = data_q;
  assign out_meta  = meta_q;

  // R2
  deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));
  // R3
  nochk_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !chk_en) |-> out_vld);
endmodule

// File: rtl/parbus_regs.sv
module parbus_regs
  import parbus_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  output logic [RDW-1:0] reg_rdata,
  input  logic [NAG-1:0] consume,
  input  logic [NAG-1:0] err_set,
  output logic           chk_en,
  output logic [NAG-1:0] inj_q,
  output logic           irq
);
  logic [1:0]     ctrl_q;
  logic [NAG-1:0] flg_q, inj_set, flg_clr;
  logic           berr_q, irq_q, wr_ctl, wr_inj, wr_st, any_err;

  assign wr_ctl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_inj  = reg_wr && (reg_addr == RA_INJ);
  assign wr_st   = reg_wr && (reg_addr == RA_STAT);
  assign inj_set = wr_inj ? reg_wdata[NAG-1:0] : '0;
  assign flg_clr = wr_st ? reg_wdata[NAG-1:0] : '0;
  assign any_err = |err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      inj_q  <= '0;
      flg_q  <= '0;
      berr_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctl) ctrl_q <= reg_wdata[1:0];
      inj_q  <= (inj_q & ~consume) | inj_set;
      flg_q  <= (flg_q & ~flg_clr) | err_set;
      berr_q <= (berr_q & ~(wr_st & reg_wdata[NAG])) | any_err;
      irq_q  <= berr_q & ctrl_q[1];
    end
  end

  assign chk_en = ctrl_q[0];
  assign irq    = irq_q;

  always_comb begin
    unique case (reg_addr)
      RA_CTRL: reg_rdata = RDW'(ctrl_q);
      RA_INJ:  reg_rdata = RDW'(inj_q);
      RA_STAT: reg_rdata = {berr_q, flg_q};
      default: reg_rdata = '0;
    endcase
  end

  // R6
  berr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |=> berr_q);
  // R10
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && reg_wdata[NAG] && !any_err) |=> !berr_q);
  // R9
  inj_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(consume & ~inj_set)) |=> ((inj_q & $past(consume & ~inj_set)) == '0));
  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(berr_q && ctrl_q[1]));
  // R3
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !reg_wr) |=> $stable({berr_q, flg_q}));
endmodule

// File: rtl/parbus_guard.sv
module parbus_guard
  import parbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  output logic [RDW-1:0] reg_rdata,
  input  logic           req_vld,
  input  logic           req_we,
  input  logic [AGW-1:0] req_src,
  input  logic [AGW-1:0] req_dst,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           tgt_vld,
  output logic           tgt_we,
  output logic [AGW-1:0] tgt_src,
  output logic [AGW-1:0] tgt_dst,
  output logic [AW-1:0]  tgt_addr,
  output logic [DW-1:0]  tgt_wdata,
  input  logic           rsp_vld,
  input  logic [AGW-1:0] rsp_src,
  input  logic [AGW-1:0] rsp_dst,
  input  logic [AW-1:0]  rsp_addr,
  input  logic [DW-1:0]  rsp_rdata,
  output logic           ret_vld,
  output logic [AGW-1:0] ret_src,
  output logic [AGW-1:0] ret_dst,
  output logic [AW-1:0]  ret_addr,
  output logic [DW-1:0]  ret_rdata,
  output logic           irq
);
  localparam int QMW = 1 + 2 * AGW;
  localparam int PMW = 2 * AGW;

  logic           chk_en, req_err, rsp_err, inj_req_a, inj_req_d, inj_rsp_d;
  logic [NAG-1:0] inj_q, consume, err_set;
  logic [QMW-1:0] req_meta_q;
  logic [PMW-1:0] rsp_meta_q;

  // which pending injection a transfer entering this cycle would use
  assign consume[INJ_BM_ADDR] = req_vld && (req_src == AG_BM);
  assign consume[INJ_BM_WDAT] = req_vld && (req_src == AG_BM) && req_we;
  assign consume[INJ_BRG_RD]  = rsp_vld && (rsp_src == AG_BRG);
  assign consume[INJ_SRAM_RD] = rsp_vld && (rsp_src == AG_SRAM);

  assign inj_req_a = inj_q[INJ_BM_ADDR] & consume[INJ_BM_ADDR];
  assign inj_req_d = inj_q[INJ_BM_WDAT] & consume[INJ_BM_WDAT];
  assign inj_rsp_d = (inj_q[INJ_BRG_RD] & consume[INJ_BRG_RD]) |
                     (inj_q[INJ_SRAM_RD] & consume[INJ_SRAM_RD]);

  parbus_hop #(.AW(AW), .DW(DW), .MW(QMW)) u_req_hop (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
    .in_vld(req_vld), .in_dchk(req_we), .in_addr(req_addr),
    .in_data(req_wdata), .in_meta({req_we, req_src, req_dst}),
    .inj_a(inj_req_a), .inj_d(inj_req_d),
    .out_vld(tgt_vld), .out_addr(tgt_addr), .out_data(tgt_wdata),
    .out_meta(req_meta_q), .err_pulse(req_err)
  );

  parbus_hop #(.AW(AW), .DW(DW), .MW(PMW)) u_rsp_hop (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
    .in_vld(rsp_vld), .in_dchk(1'b1), .in_addr(rsp_addr),
    .in_data(rsp_rdata), .in_meta({rsp_src, rsp_dst}),
    .inj_a(1'b0), .inj_d(inj_rsp_d),
    .out_vld(ret_vld), .out_addr(ret_addr), .out_data(ret_rdata),
    .out_meta(rsp_meta_q), .err_pulse(rsp_err)
  );

  assign {tgt_we, tgt_src, tgt_dst} = req_meta_q;
  assign {ret_src, ret_dst}         = rsp_meta_q;

  // detector attribution: target checks requests, requester checks responses
  always_comb begin
    err_set = '0;
    if (req_err) err_set[tgt_dst] = 1'b1;
    if (rsp_err) err_set[ret_dst] = 1'b1;
  end

  parbus_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .consume(consume),
    .err_set(err_set), .chk_en(chk_en), .inj_q(inj_q), .irq(irq)
  );

  // R5
  attrib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_err || rsp_err) |-> $onehot0(err_set) || (req_err && rsp_err));
  // R4
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |-> !(tgt_vld && ret_vld && req_err && rsp_err));
endmodule

// File: tb/parbus_guard_test.sv
module parbus_guard_test;
  localparam int CLK_NS = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [4:0] reg_wdata = '0, reg_rdata;
  logic req_vld = 0, req_we = 0;
  logic [1:0] req_src = 0, req_dst = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic tgt_vld, tgt_we;
  logic [1:0] tgt_src, tgt_dst;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_wdata;
  logic rsp_vld = 0;
  logic [1:0] rsp_src = 0, rsp_dst = 0;
  logic [AW-1:0] rsp_addr = '0;
  logic [DW-1:0] rsp_rdata = '0;
  logic ret_vld;
  logic [1:0] ret_src, ret_dst;
  logic [AW-1:0] ret_addr;
  logic [DW-1:0] ret_rdata;
  logic irq;

  int vectors = 0, fails = 0;
  bit done = 0;

  parbus_guard #(.AW(AW), .DW(DW)) uut (.*);

  always #(CLK_NS/2) clk = ~clk;

  // {is_rsp, we, src, dst, addr, data, inj, exp_vld, exp_stat}
  localparam logic [63:0] VEC [0:NV-1] = '{
    {1'b0, 1'b1, 2'd1, 2'd3, 16'h1234, 32'hA5A5A5A5, 4'b0000, 1'b1, 5'b00000},
    {1'b0, 1'b0, 2'd0, 2'd2, 16'hFFFF, 32'h00000000, 4'b0000, 1'b1, 5'b00000},
    {1'b0, 1'b1, 2'd0, 2'd3, 16'h0F01, 32'h12345678, 4'b0001, 1'b0, 5'b11000},
    {1'b0, 1'b0, 2'd0, 2'd2, 16'h8000, 32'h00000000, 4'b0001, 1'b0, 5'b10100},
    {1'b0, 1'b1, 2'd0, 2'd1, 16'h0003, 32'hFFFFFFFE, 4'b0010, 1'b0, 5'b10010},
    {1'b1, 1'b0, 2'd2, 2'd1, 16'h00C0, 32'hDEADBEEF, 4'b0100, 1'b0, 5'b10010},
    {1'b1, 1'b0, 2'd3, 2'd0, 16'h7777, 32'h00000001, 4'b1000, 1'b0, 5'b10001},
    {1'b1, 1'b0, 2'd3, 2'd1, 16'h2468, 32'hCAFEF00D, 4'b0000, 1'b1, 5'b00000}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [4:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic send_req(input logic we, input logic [1:0] s, input logic [1:0] t,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_vld = 1'b1; req_we = we; req_src = s; req_dst = t; req_addr = a; req_wdata = d;
    tick();
    req_vld = 1'b0;
  endtask

  task automatic send_rsp(input logic [1:0] s, input logic [1:0] t,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
    rsp_vld = 1'b1; rsp_src = s; rsp_dst = t; rsp_addr = a; rsp_rdata = d;
    tick();
    rsp_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 50000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [4:0] r;
    tick(); tick();
    // R1 reset state, sampled while reset is still held
    rd(2'd0, r); chk("R1 ctrl", 64'(r), 64'd0);
    rd(2'd1, r); chk("R1 inj", 64'(r), 64'd0);
    rd(2'd2, r); chk("R1 stat", 64'(r), 64'd0);
    chk("R1 irq/valids", {61'd0, irq, tgt_vld, ret_vld}, 64'd0);
    rst_n = 1'b1;
    tick();
    rd(2'd2, r); chk("R1 stat after release", 64'(r), 64'd0);

    // vector walk: checking on, interrupt off (R2 R4 R5 R6 R8 R9)
    wr(2'd0, 5'b00001);
    for (int i = 0; i < NV; i++) begin
      logic [63:0] v;
      v = VEC[i];
      if (v[9:6] != 4'b0000) wr(2'd1, {1'b0, v[9:6]});
      if (v[63]) begin
        send_rsp(v[61:60], v[59:58], v[57:42], v[41:10]);
        chk($sformatf("R4 vec%0d ret_vld", i), 64'(ret_vld), 64'(v[5]));
        if (v[5]) chk($sformatf("R2 vec%0d ret payload", i),
                      {ret_src, ret_dst, ret_addr, ret_rdata},
                      {v[61:60], v[59:58], v[57:42], v[41:10]});
      end else begin
        send_req(v[62], v[61:60], v[59:58], v[57:42], v[41:10]);
        chk($sformatf("R4 vec%0d tgt_vld", i), 64'(tgt_vld), 64'(v[5]));
        if (v[5]) chk($sformatf("R2 vec%0d tgt payload", i),
                      {tgt_we, tgt_src, tgt_dst, tgt_addr, tgt_wdata},
                      {v[62], v[61:60], v[59:58], v[57:42], v[41:10]});
      end
      tick();
      rd(2'd2, r); chk($sformatf("R5 R6 vec%0d stat", i), 64'(r), 64'(v[4:0]));
      rd(2'd1, r); chk($sformatf("R9 vec%0d inj cleared", i), 64'(r), 64'd0);
      wr(2'd2, 5'b11111);
    end

    // R3: checking off, corrupted transfer delivered, no status
    wr(2'd0, 5'b00000);
    wr(2'd1, 5'b00001);
    send_req(1'b1, 2'd0, 2'd3, 16'h00AA, 32'h55);
    chk("R3 delivered while off", 64'(tgt_vld), 64'd1);
    tick();
    rd(2'd2, r); chk("R3 no status while off", 64'(r), 64'd0);
    rd(2'd1, r); chk("R3 R9 inj consumed while off", 64'(r), 64'd0);

    // R8 scope: write-data injection survives a BM read and a non-BM write
    wr(2'd0, 5'b00001);
    wr(2'd1, 5'b00010);
    send_req(1'b0, 2'd0, 2'd3, 16'h0100, 32'h0);
    chk("R8 BM read not corrupted", 64'(tgt_vld), 64'd1);
    send_req(1'b1, 2'd1, 2'd3, 16'h0101, 32'h3);
    chk("R8 serial write not corrupted", 64'(tgt_vld), 64'd1);
    rd(2'd1, r); chk("R8 wdata inj still pending", 64'(r), 64'b00010);
    send_req(1'b1, 2'd0, 2'd2, 16'h0102, 32'h7);
    chk("R8 BM write aborted", 64'(tgt_vld), 64'd0);
    tick();
    rd(2'd2, r); chk("R8 bridge flag", 64'(r), 64'b10100);
    send_req(1'b1, 2'd0, 2'd2, 16'h0102, 32'h7);
    chk("R9 next BM write clean", 64'(tgt_vld), 64'd1);
    wr(2'd2, 5'b11111);

    // R8 response scope: bridge injection untouched by SRAM response
    wr(2'd1, 5'b00100);
    send_rsp(2'd3, 2'd0, 16'h0200, 32'h9);
    chk("R8 SRAM rsp not corrupted", 64'(ret_vld), 64'd1);
    rd(2'd1, r); chk("R8 bridge inj pending", 64'(r), 64'b00100);
    send_rsp(2'd2, 2'd0, 16'h0201, 32'h9);
    chk("R8 bridge rsp aborted", 64'(ret_vld), 64'd0);
    tick();
    rd(2'd2, r); chk("R5 rsp flag to requester", 64'(r), 64'b10001);
    wr(2'd2, 5'b11111);

    // R7 interrupt timing
    wr(2'd0, 5'b00011);
    tick(); tick();
    chk("R7 irq low when clean", 64'(irq), 64'd0);
    wr(2'd1, 5'b00001);
    send_req(1'b0, 2'd0, 2'd1, 16'h0300, 32'h0);
    tick();
    rd(2'd2, r); chk("R7 status set", 64'(r), 64'b10010);
    chk("R7 irq not yet", 64'(irq), 64'd0);
    tick();
    chk("R7 irq raised", 64'(irq), 64'd1);
    wr(2'd2, 5'b11111);
    chk("R7 irq one stage behind clear", 64'(irq), 64'd1);
    tick();
    chk("R7 irq dropped", 64'(irq), 64'd0);
    wr(2'd0, 5'b00001);
    wr(2'd1, 5'b00001);
    send_req(1'b0, 2'd0, 2'd1, 16'h0301, 32'h0);
    tick(); tick();
    chk("R7 irq masked", 64'(irq), 64'd0);
    wr(2'd2, 5'b11111);

    // R10 clear and set in the same cycle
    wr(2'd1, 5'b00001);
    send_req(1'b1, 2'd0, 2'd3, 16'h0400, 32'h1);
    tick();
    rd(2'd2, r); chk("R10 older flag set", 64'(r), 64'b11000);
    wr(2'd1, 5'b00001);
    req_vld = 1'b1; req_we = 1'b1; req_src = 2'd0; req_dst = 2'd2;
    req_addr = 16'h0401; req_wdata = 32'h2;
    tick();
    req_vld = 1'b0;
    wr(2'd2, 5'b11111);
    rd(2'd2, r); chk("R10 set wins, old cleared", 64'(r), 64'b10100);
    wr(2'd2, 5'b11111);
    rd(2'd2, r); chk("R10 plain clear", 64'(r), 64'd0);

    finish_run();
  end
endmodule